// File: doc/BRIEF.md
# I2C Status Flag Sequencer

This block keeps the three event flags of an I2C controller's first status register and clears them through two-step software access sequences. The I2C engine raises single-cycle strobes for four events: a start condition was sent, an address was sent in master mode, an own address was matched in slave mode, and a byte finished. A bus decoder supplies one-cycle strobes for a read of status register 1, a read of status register 2, and a read or write of the data register. The block returns the flags as single bits and as a 16-bit status register 1 read value.

Each flag has an internal armed bit. A status register 1 read arms every flag that is 1 at the time of the read. The matching second access then clears an armed flag. A new set event always wins over a clear in the same cycle, and that event also disarms the flag. While the peripheral enable is low, all flags and armed bits are held at zero.

Top module: `i2c_stat_seq`

## Requirements
- R1: After reset every flag is 0 and the status register 1 read value is 16'h0000.
- R2: While enabled, a start-sent strobe sets bit 0, an address-sent or address-matched strobe sets bit 1, and a byte-done strobe sets bit 2. Each flag is visible one clock after its strobe.
- R3: Bit 0 (start-sent) clears one clock after a data register write, if a status register 1 read made while the bit was 1 came earlier.
- R4: Bit 1 (address) clears one clock after a status register 2 read, if a status register 1 read made while the bit was 1 came earlier.
- R5: Bit 2 (byte done) clears one clock after a data register read or a data register write, if a status register 1 read made while the bit was 1 came earlier.
- R6: A second access with no earlier arming status register 1 read leaves the flag at 1. A status register 1 read by itself never clears a flag.
- R7: A second access of the wrong kind does not clear a flag. A status register 2 read does not clear bit 0 or bit 2, and a data register access does not clear bit 1.
- R8: A set event in the same cycle as a qualifying clearing access keeps the flag at 1 and drops its armed state. A later second access with no new status register 1 read then leaves the flag at 1.
- R9: While the enable is 0, all flags read 0 and set strobes have no effect. Arming made before the disable does not survive it.
- R10: Bits 15:3 of the status register 1 read value are always 0. Bits 2:0 equal the byte-done, address and start-sent flags in that order.
- R11: A status register 1 read made while a flag is 0 does not arm that flag for a later set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Peripheral enable; low clears all flags |
| start_sent_i | input | 1 | Start condition transmitted strobe |
| addr_sent_i | input | 1 | Master address transmission finished strobe |
| addr_match_i | input | 1 | Slave own address matched strobe |
| byte_done_i | input | 1 | Byte transfer complete strobe |
| rd_sr1_i | input | 1 | Status register 1 read strobe |
| rd_sr2_i | input | 1 | Status register 2 read strobe |
| wr_dat_i | input | 1 | Data register write strobe |
| rd_dat_i | input | 1 | Data register read strobe |
| start_flag_o | output | 1 | Start-sent flag |
| addr_flag_o | output | 1 | Address flag |
| btc_flag_o | output | 1 | Byte-transfer-complete flag |
| sr1_rdata_o | output | 16 | Status register 1 read value |

## Verification
The bench applies second accesses with no arming read and of the wrong kind. A design that ignores the armed bit, or that decodes the clearing access for the wrong flag, drops a flag that software has not yet acknowledged. It also drives a set strobe in the same cycle as a qualifying clear. A design that lets the clear win loses an event, and one that keeps the armed bit clears the new event on the next stray access. Further tests arm a flag just before a disable, and read status register 1 while a flag is still 0. A design that keeps stale arming across a disable, or arms on a zero flag, clears a later event that should stay set.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int SR1_W     = 16;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_START = 0;
  localparam int FLG_ADDR  = 1;
  localparam int FLG_BTC   = 2;

  // which second access clears each flag, one bit per flag index
  localparam logic [NUM_FLAGS-1:0] CLR_WR_DAT_MASK = 3'b101;
  localparam logic [NUM_FLAGS-1:0] CLR_RD_DAT_MASK = 3'b100;
  localparam logic [NUM_FLAGS-1:0] CLR_RD_SR2_MASK = 3'b010;

  typedef struct packed {
    logic rd_sr1;
    logic rd_sr2;
    logic wr_dat;
    logic rd_dat;
  } bus_acc_t;
endpackage

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag
  import i2c_stat_pkg::*;
#(
  parameter bit CLR_WR_DAT = 1'b0,
  parameter bit CLR_RD_DAT = 1'b0,
  parameter bit CLR_RD_SR2 = 1'b0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     enable_i,
  input  logic     set_i,
  input  bus_acc_t acc_i,
  output logic     flag_o
);
  logic flag_q, armed_q;
  logic second_acc;

  assign second_acc = (CLR_WR_DAT & acc_i.wr_dat) |
                      (CLR_RD_DAT & acc_i.rd_dat) |
                      (CLR_RD_SR2 & acc_i.rd_sr2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!enable_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      // new event beats any clear and restarts the sequence
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (armed_q && second_acc) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (acc_i.rd_sr1 && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_stat_sr1_pack.sv
module i2c_stat_sr1_pack #(
  parameter int DATA_W = 16,
  parameter int FLAGS  = 3
) (
  input  logic [FLAGS-1:0]  flags_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - FLAGS;

  assign rdata_o = {{PAD_W{1'b0}}, flags_i};
endmodule

// File: rtl/i2c_stat_seq.sv
module i2c_stat_seq
  import i2c_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_sent_i,
  input  logic             addr_sent_i,
  input  logic             addr_match_i,
  input  logic             byte_done_i,
  input  logic             rd_sr1_i,
  input  logic             rd_sr2_i,
  input  logic             wr_dat_i,
  input  logic             rd_dat_i,
  output logic             start_flag_o,
  output logic             addr_flag_o,
  output logic             btc_flag_o,
  output logic [SR1_W-1:0] sr1_rdata_o
);
  bus_acc_t             acc;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;

  assign acc = '{rd_sr1: rd_sr1_i, rd_sr2: rd_sr2_i,
                 wr_dat: wr_dat_i, rd_dat: rd_dat_i};

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_START] = start_sent_i;
    set_vec[FLG_ADDR]  = addr_sent_i | addr_match_i;
    set_vec[FLG_BTC]   = byte_done_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    i2c_stat_flag #(
      .CLR_WR_DAT(CLR_WR_DAT_MASK[g]),
      .CLR_RD_DAT(CLR_RD_DAT_MASK[g]),
      .CLR_RD_SR2(CLR_RD_SR2_MASK[g])
    ) u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .enable_i(enable_i),
      .set_i   (set_vec[g]),
      .acc_i   (acc),
      .flag_o  (flags[g])
    );
  end

  i2c_stat_sr1_pack #(
    .DATA_W(SR1_W),
    .FLAGS (NUM_FLAGS)
  ) u_pack (
    .flags_i(flags),
    .rdata_o(sr1_rdata_o)
  );

  assign start_flag_o = flags[FLG_START];
  assign addr_flag_o  = flags[FLG_ADDR];
  assign btc_flag_o   = flags[FLG_BTC];
endmodule

// File: rtl/i2c_stat_seq_chk.sv
module i2c_stat_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        start_sent_i,
  input logic        addr_sent_i,
  input logic        addr_match_i,
  input logic        byte_done_i,
  input logic        rd_sr1_i,
  input logic        rd_sr2_i,
  input logic        wr_dat_i,
  input logic        rd_dat_i,
  input logic        start_flag_o,
  input logic        addr_flag_o,
  input logic        btc_flag_o,
  input logic [15:0] sr1_rdata_o
);
  a_r2_start_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && start_sent_i |=> start_flag_o);
  a_r2_addr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && (addr_sent_i || addr_match_i) |=> addr_flag_o);
  a_r2_btc_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && byte_done_i |=> btc_flag_o);
  a_r3_start_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && start_flag_o && !wr_dat_i |=> start_flag_o);
  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && addr_flag_o && !rd_sr2_i |=> addr_flag_o);
  a_r5_btc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && btc_flag_o && !wr_dat_i && !rd_dat_i |=> btc_flag_o);
  a_r6_sr1_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && rd_sr1_i && !rd_sr2_i && !wr_dat_i && !rd_dat_i
    |=> (($past(sr1_rdata_o[2:0]) & ~sr1_rdata_o[2:0]) == 3'b000));
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && start_sent_i && wr_dat_i |=> start_flag_o);
  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> sr1_rdata_o == 16'h0000);
  a_r10_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr1_rdata_o == {13'b0, btc_flag_o, addr_flag_o, start_flag_o});
endmodule

bind i2c_stat_seq i2c_stat_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .start_sent_i(start_sent_i),
  .addr_sent_i (addr_sent_i),
  .addr_match_i(addr_match_i),
  .byte_done_i (byte_done_i),
  .rd_sr1_i    (rd_sr1_i),
  .rd_sr2_i    (rd_sr2_i),
  .wr_dat_i    (wr_dat_i),
  .rd_dat_i    (rd_dat_i),
  .start_flag_o(start_flag_o),
  .addr_flag_o (addr_flag_o),
  .btc_flag_o  (btc_flag_o),
  .sr1_rdata_o (sr1_rdata_o)
);

// File: tb/sim_i2c_stat_seq.sv
module sim_i2c_stat_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic ss = 0, as = 0, am = 0, bd = 0, r1 = 0, r2 = 0, wd = 0, rd = 0;
  logic sf, af, bf;
  logic [15:0] sr1;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .start_sent_i(ss), .addr_sent_i(as), .addr_match_i(am), .byte_done_i(bd),
    .rd_sr1_i(r1), .rd_sr2_i(r2), .wr_dat_i(wd), .rd_dat_i(rd),
    .start_flag_o(sf), .addr_flag_o(af), .btc_flag_o(bf), .sr1_rdata_o(sr1)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of strobes: {ss,as,am,bd,r1,r2,wd,rd}; result visible after return
  task automatic step(input logic [7:0] v);
    @(negedge clk);
    {ss, as, am, bd, r1, r2, wd, rd} = v;
    @(negedge clk);
    {ss, as, am, bd, r1, r2, wd, rd} = '0;
  endtask

  localparam logic [7:0] S_SS = 8'h80, S_AS = 8'h40, S_AM = 8'h20, S_BD = 8'h10,
                         S_R1 = 8'h08, S_R2 = 8'h04, S_WD = 8'h02, S_RD = 8'h01;

  task automatic clear_all();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 reset sr1", sr1, 16'h0000);
    chk("R1 reset flags", {13'b0, bf, af, sf}, 16'h0000);
  endtask

  task automatic t_set();
    clear_all();
    step(S_SS);  chk("R2 start sets bit0", sr1, 16'h0001);
    step(S_AS);  chk("R2 addr sent sets bit1", sr1, 16'h0003);
    step(S_BD);  chk("R2 byte done sets bit2", sr1, 16'h0007);
    chk("R10 flags and sr1 agree", {13'b0, bf, af, sf}, 16'h0007);
    clear_all();
    step(S_AM);  chk("R2 addr match sets bit1", sr1, 16'h0002);
  endtask

  task automatic t_clear_start();
    clear_all();
    step(S_SS);
    step(S_WD);  chk("R6 write without arm keeps start", sr1, 16'h0001);
    step(S_R1);  chk("R6 sr1 read alone keeps start", sr1, 16'h0001);
    step(S_R2);  chk("R7 sr2 read keeps start", sr1, 16'h0001);
    step(S_RD);  chk("R7 data read keeps start", sr1, 16'h0001);
    step(S_WD);  chk("R3 sr1 read then data write clears start", sr1, 16'h0000);
  endtask

  task automatic t_clear_addr();
    clear_all();
    step(S_AS);
    step(S_R2);  chk("R6 sr2 read without arm keeps addr", sr1, 16'h0002);
    step(S_R1);
    step(S_WD);  chk("R7 data write keeps addr", sr1, 16'h0002);
    step(S_RD);  chk("R7 data read keeps addr", sr1, 16'h0002);
    step(S_R2);  chk("R4 sr1 then sr2 read clears addr", sr1, 16'h0000);
  endtask

  task automatic t_clear_btc();
    clear_all();
    step(S_BD);
    step(S_R1);
    step(S_R2);  chk("R7 sr2 read keeps btc", sr1, 16'h0004);
    step(S_RD);  chk("R5 sr1 then data read clears btc", sr1, 16'h0000);
    step(S_BD);
    step(S_R1);
    step(S_WD);  chk("R5 sr1 then data write clears btc", sr1, 16'h0000);
    step(S_BD | S_SS);
    step(S_R1);
    step(S_WD);  chk("R5 R3 one write clears both", sr1, 16'h0000);
  endtask

  task automatic t_race();
    clear_all();
    step(S_SS);
    step(S_R1);
    step(S_SS | S_WD); chk("R8 set beats clear", sr1, 16'h0001);
    step(S_WD);  chk("R8 arm dropped by set", sr1, 16'h0001);
    step(S_R1);
    step(S_WD);  chk("R8 rearm then clear", sr1, 16'h0000);
  endtask

  task automatic t_noarm();
    clear_all();
    step(S_R1);
    step(S_SS | S_AS);
    step(S_WD | S_R2); chk("R11 read at zero does not arm", sr1, 16'h0003);
  endtask

  task automatic t_disable();
    clear_all();
    step(S_SS | S_AS | S_BD);
    step(S_R1);
    @(negedge clk); en = 1'b0; {ss, as, bd} = 3'b111;
    @(negedge clk); {ss, as, bd} = 3'b000;
    chk("R9 disable clears and ignores sets", sr1, 16'h0000);
    step(S_AM | S_BD);
    chk("R9 sets ignored while disabled", sr1, 16'h0000);
    @(negedge clk); en = 1'b1;
    step(S_SS | S_AS | S_BD);
    step(S_WD | S_R2 | S_RD); chk("R9 arming lost over disable", sr1, 16'h0007);
    chk("R10 upper bits zero", {sr1[15:3], 3'b000}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    en = 1'b1;
    t_set();
    t_clear_start();
    t_clear_addr();
    t_clear_btc();
    t_race();
    t_noarm();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule